// File: doc/BRIEF.md
# Swipe Sensor Readout Sequencer

This block sits on the host side of a line-scan thermal image sensor. It owns the sensor's reset, pixel clock and active-low output-enable lines, and it passes a temperature-boost request through to the sensor. It captures the 8-bit data bus once per pixel clock. Each captured byte carries two 4-bit pixels.

A start command runs the power-up sequence. Reset is held high for a fixed number of cycles and then released. The controller then issues a fixed number of warm-up clock pulses to fill the sensor pipeline. After that it reads frames of 281 columns × 4 bytes, which is 1124 pulses per frame.

Frame bursts begin on a strictly periodic schedule, so the integration time stays regular. A downstream hold that is present at a scheduled start forfeits that slot and raises an overrun pulse. The following burst still starts on the next period boundary, so the cadence never shifts.

After every reset, the first frame plus a programmable number of further frames are discarded. Later frames leave as a byte stream with a start-of-frame marker. A stop command parks the sensor in a low-power nap once the current burst has finished, and a new start command leaves the nap.

Top module: `swipe_rdout`

## Requirements
- R1: After system reset the sensor reset output is 1, the sensor clock is 0, the active-low output enable is 1, and the boost output, `px_valid_o` and `overrun_o` are 0.
- R2: A start pulse while napping holds the sensor reset high for exactly RST_HOLD (default 8) cycles after the start edge and then drops it, with output enable driven low. Exactly WARMUP (default 4) clock pulses then precede the first frame pulse.
- R3: Each frame burst is exactly COLS×BYTES_PER_COL (default 1124) clock pulses, after which the clock parks low.
- R4: Bursts 0..skip after a reset are discarded, where skip is `skip_frames_i` latched at start. Every later burst delivers each byte once, in order, with `px_sof_o` set on its first byte only.
- R5: Successive bursts begin exactly `frame_period_i` system cycles apart, measured between their first rising clock edges.
- R6: If `hold_i` is 1 at a scheduled start, that slot gets no clock pulses and `overrun_o` pulses once. The next burst starts one further period later.
- R7: Every high phase, and every low phase within a burst or warm-up, lasts max(`half_div_i`, MIN_HALF) cycles, with MIN_HALF defaulting to 2. A value of 0 is therefore clamped.
- R8: The byte is captured in the last system cycle of each high phase, and `px_valid_o` follows one cycle later. Byte n of a reset-relative pulse count is the value the sensor presented after rising edge n.
- R9: Output enable changes only while the clock is low, and at least GUARD_CYC (default 16) cycles after the last falling clock edge.
- R10: A stop pulse takes effect after the current burst. The nap state drives reset 1, clock 0, output enable 1 and boost 0. Outside nap, boost follows `boost_req_i`.
- R11: A start from nap reruns the whole reset, warm-up and skip sequence with freshly latched settings.
- R12: The sensor reset is low whenever the sensor clock is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted in nap |
| stop_i | input | 1 | Stop pulse, enters nap after the current burst |
| half_div_i | input | DIV_W | Clock half period in system cycles |
| frame_period_i | input | PER_W | Frame start period in system cycles |
| skip_frames_i | input | SKIP_W | Extra frames discarded after the first |
| hold_i | input | 1 | Downstream not ready for a new frame |
| boost_req_i | input | 1 | Temperature boost request |
| sns_data_i | input | 2*PIX_W | Sensor byte bus |
| sns_rst_o | output | 1 | Sensor reset |
| sns_clk_o | output | 1 | Sensor pixel clock |
| sns_oe_n_o | output | 1 | Sensor output enable, active low |
| sns_boost_o | output | 1 | Temperature boost enable |
| px_data_o | output | 2*PIX_W | Captured byte |
| px_valid_o | output | 1 | Captured byte valid |
| px_sof_o | output | 1 | First byte of a kept frame |
| overrun_o | output | 1 | Slot lost to a hold |

## Verification
Each result has a fixed latency that the checks respect:

- The sensor reset falls RST_HOLD edges after the edge that samples start.
- A byte appears on `px_valid_o` one cycle after the final high cycle of its pulse.
- `overrun_o` follows the missed slot by one cycle.
- Burst starts are separated by exactly one period, or by two when a slot was held.

The bench samples every output on the falling system-clock edge. It counts phase lengths and inter-burst gaps in whole system cycles. A sensor model advances its pixel index on each observed rising edge, so a misplaced capture or a wrong warm-up count shows up as a data mismatch in the scoreboard.

// File: rtl/swipe_rdout_pkg.sv
package swipe_rdout_pkg;

  typedef enum logic [1:0] {
    SEQ_NAP  = 2'd0,
    SEQ_RST  = 2'd1,
    SEQ_WARM = 2'd2,
    SEQ_RUN  = 2'd3
  } seq_state_t;

  // Lower bound applied to a programmed count.
  function automatic logic [31:0] at_least(logic [31:0] v, logic [31:0] lo);
    return (v < lo) ? lo : v;
  endfunction

  // Pulses needed to read one whole frame.
  function automatic int unsigned pulses_per_frame(int unsigned cols, int unsigned bpc);
    return cols * bpc;
  endfunction

endpackage

// File: rtl/swipe_rdout_clkdiv.sv
module swipe_rdout_clkdiv #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] half_i,
  output logic             sclk_o,
  output logic             rise_tick_o,
  output logic             fall_tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             sclk_q;
  logic             tick;

  assign tick        = run_i && (cnt_q == '0);
  assign rise_tick_o = tick && !sclk_q;
  assign fall_tick_o = tick && sclk_q;
  assign sclk_o      = sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q  <= half_i - 1'b1;
      sclk_q <= 1'b0;
    end else if (tick) begin
      cnt_q  <= half_i - 1'b1;
      sclk_q <= !sclk_q;
    end else begin
      cnt_q  <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/swipe_rdout_seq.sv
module swipe_rdout_seq
  import swipe_rdout_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int PER_W       = 16,
  parameter int SKIP_W      = 8,
  parameter int FRAME_BYTES = 1124,
  parameter int RST_HOLD    = 8,
  parameter int WARMUP      = 4,
  parameter int MIN_HALF    = 2,
  parameter int GUARD_CYC   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [DIV_W-1:0]  half_i,
  input  logic [PER_W-1:0]  period_i,
  input  logic [SKIP_W-1:0] skip_i,
  input  logic              hold_i,
  input  logic              fall_tick_i,
  output logic [DIV_W-1:0]  half_o,
  output logic              run_o,
  output logic              sns_rst_o,
  output logic              sns_oe_n_o,
  output logic              nap_o,
  output logic              cap_en_o,
  output logic              first_byte_o,
  output logic              overrun_o
);
  localparam int BC_W = $clog2(FRAME_BYTES);
  localparam int RH_W = $clog2(RST_HOLD + 1);
  localparam int WU_W = $clog2(WARMUP + 1);
  localparam int G_W  = $clog2(GUARD_CYC + 1);
  localparam logic [BC_W-1:0] LAST_BYTE = BC_W'(FRAME_BYTES - 1);

  seq_state_t        state_q;
  logic [RH_W-1:0]   rcnt_q;
  logic [WU_W-1:0]   wcnt_q;
  logic [BC_W-1:0]   bcnt_q;
  logic              burst_q, keep_q, stop_q, ovr_q;
  logic [SKIP_W:0]   fseen_q;
  logic [SKIP_W-1:0] skip_q;
  logic [PER_W-1:0]  per_q, per_cnt_q;
  logic [DIV_W-1:0]  half_q;
  logic [G_W-1:0]    gcnt_q;

  // Named events for the checks.
  logic guard_ok, slot_now, burst_done;
  assign guard_ok   = (gcnt_q == G_W'(GUARD_CYC));
  assign slot_now   = (state_q == SEQ_RUN) && (per_cnt_q == '0);
  assign burst_done = burst_q && fall_tick_i && (bcnt_q == LAST_BYTE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= SEQ_NAP;
      rcnt_q    <= '0;
      wcnt_q    <= '0;
      bcnt_q    <= '0;
      burst_q   <= 1'b0;
      keep_q    <= 1'b0;
      stop_q    <= 1'b0;
      ovr_q     <= 1'b0;
      fseen_q   <= '0;
      skip_q    <= '0;
      per_q     <= PER_W'(1);
      per_cnt_q <= '0;
      half_q    <= DIV_W'(MIN_HALF);
      gcnt_q    <= G_W'(GUARD_CYC);
    end else begin
      ovr_q <= 1'b0;

      if (fall_tick_i)   gcnt_q <= '0;
      else if (!guard_ok) gcnt_q <= gcnt_q + 1'b1;

      if (stop_i && state_q != SEQ_NAP) stop_q <= 1'b1;

      unique case (state_q)
        SEQ_NAP: begin
          if (start_i) begin
            state_q <= SEQ_RST;
            rcnt_q  <= '0;
            fseen_q <= '0;
            skip_q  <= skip_i;
            per_q   <= PER_W'(at_least(32'(period_i), 32'd1));
            half_q  <= DIV_W'(at_least(32'(half_i), 32'(MIN_HALF)));
          end
        end
        SEQ_RST: begin
          rcnt_q <= rcnt_q + 1'b1;
          if (rcnt_q == RH_W'(RST_HOLD - 1) && guard_ok) begin
            state_q <= SEQ_WARM;
            wcnt_q  <= '0;
          end
        end
        SEQ_WARM: begin
          if (fall_tick_i) begin
            wcnt_q <= wcnt_q + 1'b1;
            if (wcnt_q == WU_W'(WARMUP - 1)) begin
              state_q   <= SEQ_RUN;
              per_cnt_q <= '0;
            end
          end
        end
        SEQ_RUN: begin
          if (per_cnt_q == '0) per_cnt_q <= per_q - 1'b1;
          else                 per_cnt_q <= per_cnt_q - 1'b1;

          if (burst_q && fall_tick_i) begin
            bcnt_q <= bcnt_q + 1'b1;
            if (burst_done) burst_q <= 1'b0;
          end

          if (stop_q && !burst_q && guard_ok) begin
            state_q <= SEQ_NAP;
            stop_q  <= 1'b0;
          end else if (slot_now) begin
            if (hold_i || burst_q) begin
              ovr_q <= 1'b1;
            end else if (!stop_q) begin
              burst_q <= 1'b1;
              bcnt_q  <= '0;
              keep_q  <= (fseen_q > {1'b0, skip_q});
              if (fseen_q <= {1'b0, skip_q}) fseen_q <= fseen_q + 1'b1;
            end
          end
        end
        default: state_q <= SEQ_NAP;
      endcase
    end
  end

  assign half_o       = half_q;
  assign run_o        = (state_q == SEQ_WARM) || burst_q;
  assign sns_rst_o    = (state_q == SEQ_NAP) || (state_q == SEQ_RST);
  assign sns_oe_n_o   = (state_q == SEQ_NAP) || (state_q == SEQ_RST);
  assign nap_o        = (state_q == SEQ_NAP);
  assign cap_en_o     = burst_q && keep_q;
  assign first_byte_o = (bcnt_q == '0);
  assign overrun_o    = ovr_q;

  assert_oe_guard_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sns_oe_n_o != $past(sns_oe_n_o)) |-> $past(guard_ok));

  assert_overrun_at_slot_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_q |-> $past(slot_now));

  assert_byte_index_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burst_q |-> (bcnt_q <= LAST_BYTE));
endmodule

// File: rtl/swipe_rdout_capture.sv
module swipe_rdout_capture #(
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fall_tick_i,
  input  logic              cap_en_i,
  input  logic              first_byte_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic [BYTE_W-1:0] data_o,
  output logic              valid_o,
  output logic              sof_o
);
  logic take;
  assign take = fall_tick_i && cap_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o  <= '0;
      valid_o <= 1'b0;
      sof_o   <= 1'b0;
    end else begin
      valid_o <= take;
      sof_o   <= take && first_byte_i;
      if (take) data_o <= data_i;
    end
  end
endmodule

// File: rtl/swipe_rdout.sv
module swipe_rdout
  import swipe_rdout_pkg::*;
#(
  parameter int PIX_W         = 4,
  parameter int DIV_W         = 8,
  parameter int PER_W         = 16,
  parameter int SKIP_W        = 8,
  parameter int COLS          = 281,
  parameter int BYTES_PER_COL = 4,
  parameter int RST_HOLD      = 8,
  parameter int WARMUP        = 4,
  parameter int MIN_HALF      = 2,
  parameter int GUARD_CYC     = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic                 stop_i,
  input  logic [DIV_W-1:0]     half_div_i,
  input  logic [PER_W-1:0]     frame_period_i,
  input  logic [SKIP_W-1:0]    skip_frames_i,
  input  logic                 hold_i,
  input  logic                 boost_req_i,
  input  logic [2*PIX_W-1:0]   sns_data_i,
  output logic                 sns_rst_o,
  output logic                 sns_clk_o,
  output logic                 sns_oe_n_o,
  output logic                 sns_boost_o,
  output logic [2*PIX_W-1:0]   px_data_o,
  output logic                 px_valid_o,
  output logic                 px_sof_o,
  output logic                 overrun_o
);
  localparam int BYTE_W      = 2 * PIX_W;
  localparam int FRAME_BYTES = pulses_per_frame(COLS, BYTES_PER_COL);

  logic [DIV_W-1:0] half_eff;
  logic run, rise_tick, fall_tick, nap, cap_en, first_byte;

  swipe_rdout_seq #(
    .DIV_W(DIV_W), .PER_W(PER_W), .SKIP_W(SKIP_W), .FRAME_BYTES(FRAME_BYTES),
    .RST_HOLD(RST_HOLD), .WARMUP(WARMUP), .MIN_HALF(MIN_HALF), .GUARD_CYC(GUARD_CYC)
  ) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .stop_i(stop_i),
    .half_i(half_div_i), .period_i(frame_period_i), .skip_i(skip_frames_i),
    .hold_i(hold_i), .fall_tick_i(fall_tick), .half_o(half_eff), .run_o(run),
    .sns_rst_o(sns_rst_o), .sns_oe_n_o(sns_oe_n_o), .nap_o(nap),
    .cap_en_o(cap_en), .first_byte_o(first_byte), .overrun_o(overrun_o)
  );

  swipe_rdout_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run), .half_i(half_eff),
    .sclk_o(sns_clk_o), .rise_tick_o(rise_tick), .fall_tick_o(fall_tick)
  );

  swipe_rdout_capture #(.BYTE_W(BYTE_W)) u_cap (
    .clk_i(clk_i), .rst_ni(rst_ni), .fall_tick_i(fall_tick), .cap_en_i(cap_en),
    .first_byte_i(first_byte), .data_i(sns_data_i), .data_o(px_data_o),
    .valid_o(px_valid_o), .sof_o(px_sof_o)
  );

  assign sns_boost_o = boost_req_i && !nap;

  assert_reset_low_while_clocking_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sns_clk_o |-> !sns_rst_o);

  assert_nap_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nap |-> (!sns_clk_o && !sns_boost_o && sns_oe_n_o));

  assert_capture_on_fall_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    px_valid_o |-> $past(fall_tick));

  assert_rise_only_when_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_tick |=> sns_clk_o);
endmodule

// File: tb/swipe_rdout_bench.sv
`timescale 1ns/1ps
module swipe_rdout_bench;
  localparam int FB    = 1124;
  localparam int RH    = 8;
  localparam int GUARD = 16;
  localparam int P     = 5000;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, start, stop, hold, boost_req;
  logic [7:0] half, sns_data, px_data;
  logic [15:0] period;
  logic [7:0] skip;
  logic sns_rst, sclk, oe_n, boost, px_valid, px_sof, ovr;

  int cyc = 0, n_run = 0, n_fail = 0, rises = 0, hrun = 0, lrun = 0, h_exp = 2;
  int last_fall = -1000, ovr_cnt = 0;
  int bt [0:7];
  logic prev_sclk = 1'b0, prev_oe = 1'b1;
  logic [8:0] expq [$];
  bit done = 0;

  function automatic logic [7:0] pat(int n);
    return 8'((n * 37) ^ (n >> 7));
  endfunction

  assign sns_data = oe_n ? 8'hzz : pat(rises);

  swipe_rdout u_swipe_rdout (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .stop_i(stop), .half_div_i(half),
    .frame_period_i(period), .skip_frames_i(skip), .hold_i(hold), .boost_req_i(boost_req),
    .sns_data_i(sns_data), .sns_rst_o(sns_rst), .sns_clk_o(sclk), .sns_oe_n_o(oe_n),
    .sns_boost_o(boost), .px_data_o(px_data), .px_valid_o(px_valid), .px_sof_o(px_sof),
    .overrun_o(ovr)
  );

  task automatic check(bit ok, string req, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push_frame(int b);
    for (int j = 0; j < FB; j++) expq.push_back({j == 0, pat(4 + FB * b + j + 1)});
  endtask

  always @(posedge clk) cyc++;

  // Monitor and sensor model, sampled away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      if (sns_rst) rises = 0;
      if (sclk && !prev_sclk) begin
        rises++;
        check(!sns_rst, "R12 reset low at rise", sns_rst, 0);
        if (rises != 1 && ((rises - 5) % FB) != 0)
          check(lrun == h_exp, "R7 low phase", lrun, h_exp);
        if (rises >= 5 && ((rises - 5) % FB) == 0 && (rises - 5) / FB < 8)
          bt[(rises - 5) / FB] = cyc;
        hrun = 1;
      end else if (sclk) hrun++;
      if (!sclk && prev_sclk) begin
        check(hrun == h_exp, "R7 high phase", hrun, h_exp);
        last_fall = cyc;
        lrun = 1;
      end else if (!sclk) lrun++;
      if (oe_n != prev_oe)
        check(!sclk && (cyc - last_fall) >= GUARD, "R9 oe guard", cyc - last_fall, GUARD);
      if (px_valid) begin
        if (expq.size() == 0) check(0, "R4 unexpected byte", px_data, -1);
        else begin
          logic [8:0] e;
          e = expq.pop_front();
          check(px_data == e[7:0], "R8 byte value", px_data, e[7:0]);
          check(px_sof == e[8], "R4 sof marker", px_sof, e[8]);
        end
      end
      if (ovr) ovr_cnt++;
      prev_sclk = sclk;
      prev_oe   = oe_n;
    end
  end

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      summary();
      $finish;
    end
  end

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_nap();
    while (!sns_rst) @(negedge clk);
  endtask

  initial begin
    int k;
    rst_n = 0; start = 0; stop = 0; hold = 0; boost_req = 1;
    half = 8'd2; period = 16'(P); skip = 8'd1;
    for (int i = 0; i < 8; i++) bt[i] = 0;
    repeat (5) @(posedge clk);
    @(negedge clk) rst_n = 1;
    @(negedge clk);
    // R1 reset state; R10 boost blocked in nap
    check(sns_rst == 1, "R1 sensor reset", sns_rst, 1);
    check(sclk == 0, "R1 clock parked", sclk, 0);
    check(oe_n == 1, "R1 oe inactive", oe_n, 1);
    check(px_valid == 0 && ovr == 0, "R1 no valid/overrun", px_valid, 0);
    check(boost == 0, "R10 boost low in nap", boost, 1'b0);

    // Run 1: skip one extra frame, hold one slot.
    push_frame(2); push_frame(3); push_frame(4);
    pulse_start();
    k = 0;
    while (sns_rst && k < 100) begin k++; @(negedge clk); end
    check(k == RH, "R2 reset hold length", k, RH);
    check(oe_n == 0, "R2 oe enabled after reset", oe_n, 0);
    check(boost == 1, "R10 boost follows request", boost, 1);

    while (rises < 5 + FB * 3 + 1) @(negedge clk);
    hold = 1;
    while (ovr_cnt == 0) @(negedge clk);
    hold = 0;
    while (rises < 5 + FB * 4 + 1) @(negedge clk);
    @(negedge clk) stop = 1;
    @(negedge clk) stop = 0;
    wait_nap();
    check(expq.size() == 0, "R4 kept frames delivered", expq.size(), 0);
    check(ovr_cnt == 1, "R6 single overrun", ovr_cnt, 1);
    check(bt[1] - bt[0] == P, "R5 period 0-1", bt[1] - bt[0], P);
    check(bt[2] - bt[1] == P, "R5 period 1-2", bt[2] - bt[1], P);
    check(bt[3] - bt[2] == P, "R5 period 2-3", bt[3] - bt[2], P);
    check(bt[4] - bt[3] == 2 * P, "R6 held slot gap", bt[4] - bt[3], 2 * P);
    check(sclk == 0 && oe_n == 1 && boost == 0, "R10 nap outputs", {sclk, oe_n, boost}, 3'b010);
    repeat (200) @(negedge clk);
    check(rises == 0 && sclk == 0, "R10 clock stays parked", rises, 0);
    check(bt[5] == 0, "R3 no burst after stop", bt[5], 0);

    // Run 2: restart from nap, half=0 clamps, skip=0.
    for (int i = 0; i < 8; i++) bt[i] = 0;
    half = 8'd0; skip = 8'd0; h_exp = 2;
    push_frame(1);
    pulse_start();
    while (expq.size() != 0) @(negedge clk);
    check(bt[1] - bt[0] == P, "R11 restart period", bt[1] - bt[0], P);
    @(negedge clk) stop = 1;
    @(negedge clk) stop = 0;
    wait_nap();
    check(sns_rst == 1 && oe_n == 1, "R11 back in nap", {sns_rst, oe_n}, 2'b11);
    repeat (50) @(negedge clk);
    check(expq.size() == 0 && !px_valid, "R4 no stray bytes", expq.size(), 0);

    done = 1;
    summary();
    $finish;
  end
endmodule